// File: doc/BRIEF.md
# Multichannel pulse interval timer

This block measures, on many input lines at the same time, the delay between a start pulse and a later, much shorter pulse. Each line has its own synchroniser, pulse-width classifier and interval counter running on a common clock of about 100 MHz, which gives about 10 ns per count. A pulse is taken as a start pulse when its high time lies inside a window set by two input ports. The width of the start pulse also carries three bits of side information. The first short pulse that follows the start stops the count.

A global timeout runs from each re-arm. When it expires, every channel freezes and a data-ready output rises. A microcontroller then clocks all results out through an SPI slave port (mode 0). Raising chip select at the end of that read clears data-ready and re-arms every channel for the next measurement frame. A prescaler parameter stretches the count step so that spans of several milliseconds fit the result width. Counts that still exceed the width saturate and raise a flag.

Top module: `multi_pulse_timer`

## Requirements
- R1: After reset, data_ready is low, spi_miso is low and every channel holds the empty result described in R7.
- R2: A high pulse of W clock cycles on a channel, measured between its synchronised rising and falling edges, starts a measurement only if start_min <= W <= start_max. While a channel waits for a start, pulses outside that window have no effect.
- R3: Once started, the first later pulse with W < start_min ends the measurement. The stored count is floor(D / PRESCALE), where D is the number of clock cycles from the start pulse's rising edge to that pulse's rising edge. Pulses with W >= start_min arriving after the start are ignored. The result is then held until the next re-arm.
- R4: When floor(D / PRESCALE) exceeds 2^CW - 1, the count reads 2^CW - 1 and the overflow flag is 1. An exact value of 2^CW - 1 leaves the flag at 0.
- R5: The 3-bit info field of a completed measurement is min((W_start - start_min) >> INFO_SH, 7).
- R6: Channels measure independently. Different pulse timings on different lines in the same frame give each line its own result.
- R7: data_ready rises TIMEOUT clock cycles (plus synchroniser delay) after a re-arm, and channels then ignore their inputs. A channel without a completed measurement reports count 2^CW - 1, info 0, valid 0 and overflow 0.
- R8: The SPI port is a mode-0 slave. The frame is loaded when chip select falls and shifts one bit per falling SCLK. Channels go out in order 0, 1, 2 and so on. Each channel sends CW+5 bits: the count MSB first, then info bit 2 down to bit 0, then the valid flag, then the overflow flag.
- R9: A rising chip select while data_ready is high clears data_ready and re-arms all channels. A new frame of measurements then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, about 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NCH | Asynchronous pulse lines, one per channel |
| start_min | input | WW | Smallest start-pulse width in clock cycles |
| start_max | input | WW | Largest start-pulse width in clock cycles |
| spi_sclk | input | 1 | SPI serial clock from the reader |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI serial data to the reader |
| data_ready | output | 1 | High when a frame of results is waiting |

## Verification
The bench uses a four-channel, 8-bit, prescale-2 configuration. It sweeps ten frames in which each line receives a different start width and a different start-to-stop delay, so a swapped channel, a wrong prescale or a shifted field shows up as a mismatch. Dedicated frames put delays on both sides of the saturation point, widths one below, at, and one above each window edge, and stray pulses before, between and after a measurement. These frames separate the classifier decisions from the counter. An empty frame and a measured re-arm interval check the timeout and the handshake.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_TIMING, CH_DONE} ch_state_e;
  localparam int INFO_W = 3;
  localparam int FLAG_W = 2;
endpackage

// File: rtl/mpt_sync_edge.sv
module mpt_sync_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic lvl_d
);
  timeunit 1ns; timeprecision 1ps;
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl   = s2;
  assign lvl_d = s3;
endmodule

// File: rtl/mpt_channel.sv
module mpt_channel import mpt_pkg::*; #(
  parameter int CW       = 16,
  parameter int WW       = 12,
  parameter int PRESCALE = 1,
  parameter int INFO_SH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              run,
  input  logic              rise,
  input  logic              fall,
  input  logic [WW-1:0]     start_min,
  input  logic [WW-1:0]     start_max,
  output logic [CW-1:0]     r_count,
  output logic [INFO_W-1:0] r_info,
  output logic              r_valid,
  output logic              r_ovf
);
  timeunit 1ns; timeprecision 1ps;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};

  ch_state_e         st;
  logic [PW-1:0]     pre, pre_nxt;
  logic [CW-1:0]     cnt, cnt_nxt, cand_cnt;
  logic              ovf_run, ovf_nxt, cand_ovf, hi, tick;
  logic [WW-1:0]     wcnt, w_nxt, w_over, w_sh;
  logic [INFO_W-1:0] info, info_nxt;
  logic              is_start, is_short;

  always_comb begin
    tick     = (pre == PW'(PRESCALE - 1));
    pre_nxt  = tick ? '0 : pre + 1'b1;
    cnt_nxt  = (tick && cnt != CMAX) ? cnt + 1'b1 : cnt;
    ovf_nxt  = ovf_run | (tick && cnt == CMAX);
    w_nxt    = (wcnt == WMAX) ? wcnt : wcnt + 1'b1;
    w_over   = w_nxt - start_min;
    w_sh     = w_over >> INFO_SH;
    info_nxt = (w_sh > WW'(7)) ? 3'd7 : w_sh[2:0];
    is_start = hi && fall && (w_nxt >= start_min) && (w_nxt <= start_max);
    is_short = hi && fall && (w_nxt < start_min);
  end

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      st       <= CH_IDLE;
      hi       <= 1'b0;
      wcnt     <= '0;
      pre      <= '0;
      cnt      <= '0;
      ovf_run  <= 1'b0;
      cand_cnt <= '0;
      cand_ovf <= 1'b0;
      info     <= '0;
      r_count  <= CMAX;
      r_info   <= '0;
      r_valid  <= 1'b0;
      r_ovf    <= 1'b0;
    end else if (run) begin
      if (rise) begin
        hi   <= 1'b1;
        wcnt <= '0;
      end else if (fall) begin
        hi <= 1'b0;
      end else begin
        wcnt <= w_nxt;
      end
      if (rise && st == CH_IDLE) begin
        pre     <= '0;
        cnt     <= '0;
        ovf_run <= 1'b0;
      end else begin
        pre     <= pre_nxt;
        cnt     <= cnt_nxt;
        ovf_run <= ovf_nxt;
      end
      case (st)
        CH_IDLE: if (is_start) begin
          st   <= CH_TIMING;
          info <= info_nxt;
        end
        CH_TIMING: begin
          if (rise) begin
            cand_cnt <= cnt_nxt;
            cand_ovf <= ovf_nxt;
          end
          if (is_short) begin
            st      <= CH_DONE;
            r_count <= cand_cnt;
            r_ovf   <= cand_ovf;
            r_info  <= info;
            r_valid <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    r_valid && !arm |=> r_valid && $stable(r_count) && $stable(r_info)); // R3
  AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (rst)
    !r_valid |-> (r_count == CMAX) && !r_ovf && (r_info == '0)); // R7
  AST_SAT_FLAG: assert property (@(posedge clk) disable iff (rst)
    r_ovf |-> r_count == CMAX); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !run && !arm |=> $stable(st) && $stable(r_valid)); // R7
endmodule

// File: rtl/mpt_spi_tx.sv
module mpt_spi_tx #(
  parameter int FB = 336
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic [FB-1:0] frame,
  output logic          miso,
  output logic          cs_rise
);
  timeunit 1ns; timeprecision 1ps;
  logic sc_l, sc_d, cs_l, cs_d, cs_fall, sc_fall;
  logic [FB-1:0] sh;

  mpt_sync_edge #(.RST_VAL(1'b0)) u_sclk (.clk(clk), .rst(rst), .d(sclk), .lvl(sc_l), .lvl_d(sc_d));
  mpt_sync_edge #(.RST_VAL(1'b1)) u_cs   (.clk(clk), .rst(rst), .d(cs_n), .lvl(cs_l), .lvl_d(cs_d));

  assign cs_fall = !cs_l && cs_d;
  assign cs_rise = cs_l && !cs_d;
  assign sc_fall = !sc_l && sc_d;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else if (cs_fall) sh <= frame;
    else if (!cs_l && sc_fall) sh <= {sh[FB-2:0], 1'b0};
  end

  assign miso = sh[FB-1];

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_l |=> $stable(sh)); // R8
endmodule

// File: rtl/multi_pulse_timer.sv
module multi_pulse_timer import mpt_pkg::*; #(
  parameter int NCH      = 16,
  parameter int CW       = 16,
  parameter int WW       = 12,
  parameter int PRESCALE = 1,
  parameter int TIMEOUT  = 1000000,
  parameter int INFO_SH  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pulse_in,
  input  logic [WW-1:0]  start_min,
  input  logic [WW-1:0]  start_max,
  input  logic           spi_sclk,
  input  logic           spi_cs_n,
  output logic           spi_miso,
  output logic           data_ready
);
  timeunit 1ns; timeprecision 1ps;
  localparam int CHB = CW + INFO_W + FLAG_W;
  localparam int FB  = NCH * CHB;
  localparam int TW  = $clog2(TIMEOUT + 1);

  logic [TW-1:0] tcnt;
  logic          arm, cs_rise;
  logic [FB-1:0] frame;

  assign arm = cs_rise & data_ready;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      tcnt       <= '0;
      data_ready <= 1'b0;
    end else if (!data_ready) begin
      if (tcnt == TW'(TIMEOUT - 1)) data_ready <= 1'b1;
      else tcnt <= tcnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              p_l, p_d, valid, ovf;
    logic [CW-1:0]     count;
    logic [INFO_W-1:0] info;

    mpt_sync_edge #(.RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst(rst), .d(pulse_in[g]), .lvl(p_l), .lvl_d(p_d));

    mpt_channel #(.CW(CW), .WW(WW), .PRESCALE(PRESCALE), .INFO_SH(INFO_SH)) u_ch (
      .clk(clk), .rst(rst), .arm(arm), .run(!data_ready),
      .rise(p_l && !p_d), .fall(!p_l && p_d),
      .start_min(start_min), .start_max(start_max),
      .r_count(count), .r_info(info), .r_valid(valid), .r_ovf(ovf));

    assign frame[FB-1-g*CHB -: CHB] = {count, info, valid, ovf};
  end

  mpt_spi_tx #(.FB(FB)) u_spi (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .frame(frame), .miso(spi_miso), .cs_rise(cs_rise));

  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    arm |=> !data_ready); // R9
  AST_DRDY_HOLD: assert property (@(posedge clk) disable iff (rst)
    data_ready && !cs_rise |=> data_ready); // R7
endmodule

// File: tb/test_multi_pulse_timer.sv
module test_multi_pulse_timer;
  timeunit 1ns; timeprecision 1ps;
  localparam int NCH = 4, CW = 8, WW = 8, PRE = 2, TMO = 3000, ISH = 2;
  localparam int MINW = 20, MAXW = 51;
  localparam int CHB = CW + 5, FB = NCH * CHB, CMAX = 255;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] pulse_in;
  logic sclk, cs_n, miso, drdy;
  int total = 0, bad = 0, cyc = 0, mark = 0;
  bit finished = 0;
  int pt [NCH][3];
  int pw [NCH][3];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  multi_pulse_timer #(.NCH(NCH), .CW(CW), .WW(WW), .PRESCALE(PRE),
                      .TIMEOUT(TMO), .INFO_SH(ISH)) i_multi_pulse_timer (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .start_min(8'(MINW)), .start_max(8'(MAXW)),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_miso(miso), .data_ready(drdy));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 3; k++) begin
        pt[c][k] = 0;
        pw[c][k] = 0;
      end
  endtask

  task automatic run_sched(int tend);
    for (int t = 0; t < tend; t++) begin
      logic [NCH-1:0] v;
      v = '0;
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 3; k++)
          if (pw[c][k] > 0 && t >= pt[c][k] && t < pt[c][k] + pw[c][k]) v[c] = 1'b1;
      pulse_in = v;
      tick(1);
    end
    pulse_in = '0;
  endtask

  task automatic read_frame(output logic [FB-1:0] f);
    cs_n = 1'b0;
    tick(8);
    for (int i = 0; i < FB; i++) begin
      f[FB-1-i] = miso;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(6);
    end
    cs_n = 1'b1;
    mark = cyc;
    tick(8);
  endtask

  task automatic do_round(string extra, bit check_time, int tend);
    logic [FB-1:0] f;
    int guard, el;
    run_sched(tend);
    guard = 0;
    while (!drdy && guard < 2 * TMO) begin
      tick(1);
      guard++;
    end
    el = cyc - mark;
    chk($sformatf("%s R7 data_ready seen", extra), int'(drdy), 1);
    if (check_time)
      chk($sformatf("R7 timeout window elapsed=%0d", el),
          int'(el >= TMO && el <= TMO + 8), 1);
    read_frame(f);
    for (int c = 0; c < NCH; c++) begin
      int base, ts, dd, einfo, ecnt, eovf, w;
      bit started, done;
      started = 0; done = 0; ts = 0; dd = 0; einfo = 0;
      for (int k = 0; k < 3; k++) begin
        w = pw[c][k];
        if (w == 0) continue;
        if (!started) begin
          if (w >= MINW && w <= MAXW) begin
            started = 1;
            ts = pt[c][k];
            einfo = (w - MINW) >> ISH;
            if (einfo > 7) einfo = 7;
          end
        end else if (!done && w < MINW) begin
          done = 1;
          dd = pt[c][k] - ts;
        end
      end
      ecnt = done ? ((dd / PRE > CMAX) ? CMAX : dd / PRE) : CMAX;
      eovf = (done && dd / PRE > CMAX) ? 1 : 0;
      if (!done) einfo = 0;
      base = FB - 1 - c * CHB;
      chk($sformatf("%s R3 count ch%0d", extra, c), int'(f[base -: 8]), ecnt);
      chk($sformatf("%s R5 info ch%0d", extra, c), int'(f[base-8 -: 3]), einfo);
      chk($sformatf("%s R2/R8 valid ch%0d", extra, c), int'(f[base-11]), int'(done));
      chk($sformatf("%s R4 ovf ch%0d", extra, c), int'(f[base-12]), eovf);
    end
    chk($sformatf("%s R9 data_ready cleared", extra), int'(drdy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pulse_in = '0; sclk = 1'b0; cs_n = 1'b1;
    tick(5);
    chk("R1 data_ready in reset", int'(drdy), 0);
    chk("R1 miso in reset", int'(miso), 0);
    rst = 1'b0;
    mark = cyc;
    // R7 / R1: empty frame
    clear_sched();
    do_round("R7 R1 empty", 0, 10);
    // R6: sweep of widths and delays across channels
    for (int r = 1; r <= 10; r++) begin
      int tend;
      clear_sched();
      tend = 0;
      for (int c = 0; c < NCH; c++) begin
        pt[c][0] = 5 + c * 3;
        pw[c][0] = MINW + ((r * 7 + c * 5) % 32);
        pt[c][1] = pt[c][0] + 30 + r * 37 + c * 53;
        pw[c][1] = 1 + ((r + c) % 19);
        if (pt[c][1] + pw[c][1] + 5 > tend) tend = pt[c][1] + pw[c][1] + 5;
      end
      do_round("R6 sweep", 1, tend);
    end
    // R4: delays around saturation
    clear_sched();
    for (int c = 0; c < NCH; c++) begin
      pt[c][0] = 5; pw[c][0] = 25;
      pt[c][1] = 5 + 509 + c; pw[c][1] = 3;
    end
    do_round("R4 saturation", 1, 540);
    // R2: window edges
    clear_sched();
    pt[0][0] = 5; pw[0][0] = MINW - 1; pt[0][1] = 100; pw[0][1] = 3;
    pt[1][0] = 5; pw[1][0] = MAXW + 1; pt[1][1] = 100; pw[1][1] = 3;
    pt[2][0] = 5; pw[2][0] = MINW;     pt[2][1] = 100; pw[2][1] = 3;
    pt[3][0] = 5; pw[3][0] = MAXW;     pt[3][1] = 100; pw[3][1] = 3;
    do_round("R2 window", 1, 120);
    // R3: stray pulses ignored
    clear_sched();
    pt[0][0] = 5;  pw[0][0] = 30; pt[0][1] = 60; pw[0][1] = 40; pt[0][2] = 150; pw[0][2] = 2;
    pt[1][0] = 5;  pw[1][0] = 30;
    pt[2][0] = 5;  pw[2][0] = 4;  pt[2][1] = 20; pw[2][1] = 30; pt[2][2] = 90;  pw[2][2] = 5;
    pt[3][0] = 5;  pw[3][0] = 30; pt[3][1] = 50; pw[3][1] = 2;  pt[3][2] = 80;  pw[3][2] = 2;
    do_round("R3 ignore", 1, 170);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule